// File: doc/BRIEF.md
# E1 Basic Frame Aligner

This block locates and then tracks basic frame alignment on a 2048 kbit/s serial stream built from 256-bit frames. The first timeslot of each frame alternates between two kinds: one carries the frame alignment word, and the other carries a 1 in its second bit. Bits arrive one per clock on `bit_in` whenever `bit_en` is high. While hunting, the block slides one bit at a time across the 512-bit two-frame period and looks for the alignment word. A candidate becomes real alignment only after a three-frame confirmation. Once aligned, the block reports where each received bit sits in the frame and whether that frame carries the alignment word.

Alignment is dropped when the alignment word is received wrong on consecutive occasions. It can optionally also be dropped when the second bit of the non-word frames is received wrong on consecutive occasions. A CRC or management function can force a fresh hunt with `resync_req`. When `resume_en` is high, the fresh hunt steps past the old candidate position once, so it cannot lock straight back onto a spurious imitation.

Top module: `e1fa_aligner`

## Requirements
- R1: A synchronous reset puts the block into the hunting state with `in_frame` low.
- R2: Bits are numbered 0 to 255 within a frame. The alignment word is 0011011, received first bit first at positions 1 to 7 of a word frame. `in_frame` goes high on the edge that accepts position 7 of frame n+2, provided the word was also seen in frame n and position 1 of frame n+1 was 1. On that edge `bit_pos` is 7 and `fas_frame` is 1.
- R3: If position 1 of frame n+1 is 0, the candidate is dropped, and the hunt restarts only at position 0 of frame n+2. Any word-like pattern in the rest of frame n+1 is ignored.
- R4: If the word is missing at frame n+2, the hunt restarts with the very next bit.
- R5: With `resume_en` high, a hunt started by `resync_req`, by a failed frame n+1 check or by the bit-2 loss rule skips the first return of the previous candidate position. A hunt started with `resume_en` low does not skip it.
- R6: While `in_frame` is high, `bit_pos` gives the position of the last accepted bit. It counts 0 to 255 and wraps. `fas_frame` is 1 in word frames and 0 in the other frames, and it flips whenever `bit_pos` wraps.
- R7: The alignment word received wrong in three consecutive word frames clears `in_frame` on the edge that accepts the third bad word. Two bad words followed by a good one leave `in_frame` high.
- R8: With `nfas_loss_en` high, a 0 at position 1 of three consecutive non-word frames clears `in_frame`. With it low, such errors have no effect.
- R9: `resync_req` clears `in_frame` on the next clock edge. The hunt then relocks onto the true word.
- R10: Position 0 of word frames is ignored when matching. Cycles with `bit_en` low change no output.
- R11: The hunt finds a word-like pattern at any bit offset, not only at frame-aligned offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Received line bit |
| resync_req | input | 1 | Forces loss of alignment and a new hunt |
| resume_en | input | 1 | New hunts skip the last candidate position once |
| nfas_loss_en | input | 1 | Enables the bit-2 loss rule |
| in_frame | output | 1 | Alignment declared |
| bit_pos | output | 8 | Position of the last accepted bit in its frame |
| fas_frame | output | 1 | Current frame carries the alignment word |

## Verification
Most wrong internal states show up as a shift in the cycle where `in_frame` rises. A confirmation window that is off by one frame, a hunt that restarts too early or too late, or a skip flag that fires at the wrong time each move the lock edge by a whole two-frame period. A wrong skip flag can also move the lock onto an imitation word. The bench therefore checks `in_frame` on both sides of each predicted edge, and it checks `bit_pos` and `fas_frame` against the absolute bit index. A position counter that slips appears at once as a `bit_pos` mismatch. A wrong loss counter appears at the third bad occasion, within six frames.

// File: rtl/e1fa_pkg.sv
`timescale 1ns/1ps
package e1fa_pkg;
   typedef enum logic [2:0] {
      ST_HUNT,
      ST_CHK_B2,
      ST_WAIT_N2,
      ST_CHK_WORD,
      ST_LOCKED
   } e1fa_state_e;

   localparam logic [6:0] E1FA_WORD_DEF = 7'b0011011;
endpackage

// File: rtl/e1fa_fas_match.sv
`timescale 1ns/1ps
module e1fa_fas_match #(
   parameter int                 FAS_LEN  = 7,
   parameter logic [FAS_LEN-1:0] FAS_WORD = 7'b0011011
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_en,
   input  logic bit_in,
   output logic match
);
   localparam int HIST_W = FAS_LEN - 1;

   logic [HIST_W-1:0]  hist;
   logic [FAS_LEN-1:0] window;

   generate
      if (HIST_W == 1) begin : g_one
         always_ff @(posedge clk) begin
            if (rst)         hist <= '1;
            else if (bit_en) hist <= bit_in;
         end
      end else begin : g_many
         always_ff @(posedge clk) begin
            if (rst)         hist <= '1;
            else if (bit_en) hist <= {hist[HIST_W-2:0], bit_in};
         end
      end
   endgenerate

   assign window = {hist, bit_in};
   assign match  = (window == FAS_WORD);
endmodule

// File: rtl/e1fa_pos_cnt.sv
`timescale 1ns/1ps
module e1fa_pos_cnt #(
   parameter int CNT_W    = 9,
   parameter int LOAD_VAL = 7
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step,
   input  logic             load,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] nxt
);
   assign nxt = cnt + 1'b1;

   always_ff @(posedge clk) begin
      if (rst)       cnt <= '0;
      else if (step) cnt <= load ? CNT_W'(LOAD_VAL) : nxt;
   end
endmodule

// File: rtl/e1fa_loss_mon.sv
`timescale 1ns/1ps
module e1fa_loss_mon #(
   parameter int FAS_THR  = 3,
   parameter int NFAS_THR = 3,
   parameter bit NFAS_MON = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic word_chk,
   input  logic word_ok,
   input  logic b2_chk,
   input  logic b2_ok,
   input  logic b2_en,
   output logic loss
);
   localparam int FW = $clog2(FAS_THR + 1);
   localparam int NW = $clog2(NFAS_THR + 1);

   logic [FW-1:0] word_errs;
   logic          word_loss;
   logic          b2_loss;

   always_ff @(posedge clk) begin
      if (rst || clr)    word_errs <= '0;
      else if (word_chk) word_errs <= word_ok ? '0 : word_errs + 1'b1;
   end
   assign word_loss = word_chk && !word_ok && (word_errs == FW'(FAS_THR - 1));

   generate
      if (NFAS_MON) begin : g_b2
         logic [NW-1:0] b2_errs;
         always_ff @(posedge clk) begin
            if (rst || clr || !b2_en) b2_errs <= '0;
            else if (b2_chk)          b2_errs <= b2_ok ? '0 : b2_errs + 1'b1;
         end
         assign b2_loss = b2_en && b2_chk && !b2_ok && (b2_errs == NW'(NFAS_THR - 1));
      end else begin : g_no_b2
         logic unused_b2;
         assign unused_b2 = ^{b2_chk, b2_ok, b2_en};
         assign b2_loss   = 1'b0;
      end
   endgenerate

   assign loss = word_loss || b2_loss;
endmodule

// File: rtl/e1fa_aligner.sv
`timescale 1ns/1ps
module e1fa_aligner #(
   parameter int                 FRAME_BITS    = 256,
   parameter int                 FAS_LEN       = 7,
   parameter logic [FAS_LEN-1:0] FAS_WORD      = 7'b0011011,
   parameter int                 FAS_END_POS   = 7,
   parameter int                 BIT2_POS      = 1,
   parameter int                 FAS_LOSS_THR  = 3,
   parameter int                 NFAS_LOSS_THR = 3,
   parameter bit                 NFAS_MON      = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          bit_en,
   input  logic                          bit_in,
   input  logic                          resync_req,
   input  logic                          resume_en,
   input  logic                          nfas_loss_en,
   output logic                          in_frame,
   output logic [$clog2(FRAME_BITS)-1:0] bit_pos,
   output logic                          fas_frame
);
   import e1fa_pkg::*;

   localparam int             POS_W     = $clog2(FRAME_BITS);
   localparam int             CNT_W     = POS_W + 1;
   localparam logic [CNT_W-1:0] END_PHASE = CNT_W'(FAS_END_POS);
   localparam logic [CNT_W-1:0] B2_PHASE  = CNT_W'(FRAME_BITS + BIT2_POS);

   generate
      if (FRAME_BITS < 16 || (FRAME_BITS & (FRAME_BITS - 1)) != 0) begin : g_bad_frame
         $error("FRAME_BITS must be a power of two of at least 16");
      end
      if (FAS_LEN < 2 || FAS_END_POS + 1 < FAS_LEN || FAS_END_POS >= FRAME_BITS) begin : g_bad_word
         $error("alignment word must fit in the frame and end at FAS_END_POS");
      end
      if (BIT2_POS >= FRAME_BITS) begin : g_bad_b2
         $error("BIT2_POS lies outside the frame");
      end
      if (FAS_LOSS_THR < 1 || NFAS_LOSS_THR < 1) begin : g_bad_thr
         $error("loss thresholds must be at least 1");
      end
   endgenerate

   e1fa_state_e      st, st_n;
   logic             skip, skip_n;
   logic             match;
   logic             load;
   logic [CNT_W-1:0] cnt, nxt;
   logic             at_end, at_b2, at_wrap;
   logic             loss;

   e1fa_fas_match #(.FAS_LEN(FAS_LEN), .FAS_WORD(FAS_WORD)) u_match (
      .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in), .match(match)
   );

   e1fa_pos_cnt #(.CNT_W(CNT_W), .LOAD_VAL(FAS_END_POS)) u_cnt (
      .clk(clk), .rst(rst), .step(bit_en), .load(load), .cnt(cnt), .nxt(nxt)
   );

   assign at_end  = (nxt == END_PHASE);
   assign at_b2   = (nxt == B2_PHASE);
   assign at_wrap = (nxt == '0);

   e1fa_loss_mon #(.FAS_THR(FAS_LOSS_THR), .NFAS_THR(NFAS_LOSS_THR), .NFAS_MON(NFAS_MON)) u_loss (
      .clk      (clk),
      .rst      (rst),
      .clr      (st != ST_LOCKED),
      .word_chk (bit_en && at_end && st == ST_LOCKED),
      .word_ok  (match),
      .b2_chk   (bit_en && at_b2 && st == ST_LOCKED),
      .b2_ok    (bit_in),
      .b2_en    (nfas_loss_en),
      .loss     (loss)
   );

   always_comb begin
      st_n   = st;
      skip_n = skip;
      load   = 1'b0;
      if (resync_req) begin
         st_n   = ST_HUNT;
         skip_n = resume_en && !(bit_en && at_end);
      end else if (bit_en) begin
         unique case (st)
            ST_HUNT: begin
               if (match && !(skip && at_end)) begin
                  load   = 1'b1;
                  st_n   = ST_CHK_B2;
                  skip_n = 1'b0;
               end else if (at_end) begin
                  skip_n = 1'b0;
               end
            end
            ST_CHK_B2: begin
               if (at_b2) begin
                  if (bit_in) st_n = ST_CHK_WORD;
                  else begin
                     st_n   = ST_WAIT_N2;
                     skip_n = resume_en;
                  end
               end
            end
            ST_WAIT_N2: begin
               if (at_wrap) st_n = ST_HUNT;
            end
            ST_CHK_WORD: begin
               if (at_end) begin
                  st_n   = match ? ST_LOCKED : ST_HUNT;
                  skip_n = 1'b0;
               end
            end
            ST_LOCKED: begin
               if (loss) begin
                  st_n   = ST_HUNT;
                  skip_n = resume_en && !at_end;
               end
            end
            default: st_n = ST_HUNT;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st   <= ST_HUNT;
         skip <= 1'b0;
      end else begin
         st   <= st_n;
         skip <= skip_n;
      end
   end

   assign in_frame  = (st == ST_LOCKED);
   assign bit_pos   = cnt[POS_W-1:0];
   assign fas_frame = ~cnt[POS_W];
endmodule

// File: rtl/e1fa_aligner_chk.sv
`timescale 1ns/1ps
module e1fa_aligner_chk #(
   parameter int FRAME_BITS  = 256,
   parameter int FAS_END_POS = 7
) (
   input logic                          clk,
   input logic                          rst,
   input logic                          bit_en,
   input logic                          resync_req,
   input logic                          in_frame,
   input logic [$clog2(FRAME_BITS)-1:0] bit_pos,
   input logic                          fas_frame
);
   localparam int POS_W = $clog2(FRAME_BITS);

   assert_lock_phase_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(in_frame) |-> $past(bit_en) && bit_pos == POS_W'(FAS_END_POS) && fas_frame);

   assert_pos_step_R6: assert property (@(posedge clk) disable iff (rst)
      in_frame && $past(in_frame) && $past(bit_en) |-> bit_pos == $past(bit_pos) + 1'b1);

   assert_parity_flip_R6: assert property (@(posedge clk) disable iff (rst)
      in_frame && $past(in_frame) && $past(bit_en) && $past(bit_pos) == POS_W'(FRAME_BITS - 1)
      |-> fas_frame != $past(fas_frame));

   assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && !$past(bit_en) && !$past(resync_req)
      |-> $stable(in_frame) && $stable(bit_pos) && $stable(fas_frame));

   assert_resync_drop_R9: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && $past(resync_req) |-> !in_frame);

   assert_fall_cause_R7: assert property (@(posedge clk) disable iff (rst)
      $fell(in_frame) |-> $past(bit_en) || $past(resync_req));
endmodule

bind e1fa_aligner e1fa_aligner_chk #(.FRAME_BITS(FRAME_BITS), .FAS_END_POS(FAS_END_POS)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .bit_en     (bit_en),
   .resync_req (resync_req),
   .in_frame   (in_frame),
   .bit_pos    (bit_pos),
   .fas_frame  (fas_frame)
);

// File: tb/e1fa_aligner_tb.sv
`timescale 1ns/1ps
module e1fa_aligner_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       bit_en = 1'b0;
   logic       bit_in = 1'b0;
   logic       resync_req = 1'b0;
   logic       resume_en = 1'b0;
   logic       nfas_loss_en = 1'b0;
   logic       in_frame;
   logic [7:0] bit_pos;
   logic       fas_frame;

   e1fa_aligner u_dut (
      .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
      .resync_req(resync_req), .resume_en(resume_en), .nfas_loss_en(nfas_loss_en),
      .in_frame(in_frame), .bit_pos(bit_pos), .fas_frame(fas_frame)
   );

   always #2 clk = ~clk;

   typedef struct {
      int at;
      int req;
      bit inf;
      int pos;
      bit fas;
   } exp_t;

   localparam logic [6:0] PAT = 7'b0011011;

   exp_t        q[$];
   exp_t        cur;
   int          nbits = 0;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;
   logic [63:0] bad_word = '0;
   logic [63:0] bad_b2 = '0;
   int          fake_end = -1;
   int          rs_at = -1;

   function automatic logic bit_of(int k);
      int f = k / 256;
      int p = k % 256;
      if (fake_end >= 0 && k >= fake_end - 6 && k <= fake_end)
         return PAT[6 - (k - (fake_end - 6))];
      if (f % 2 == 0) begin
         if (p == 0) return f[1];                 // R10: bit 1 varies
         if (p <= 7) return (p == 7 && bad_word[f]) ? 1'b0 : PAT[7 - p];
         return 1'b1;
      end
      if (p == 1) return !bad_b2[f];
      return 1'b1;
   endfunction

   task automatic check(int req, bit ok, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL R%0d %s actual=%0d expected=%0d (bits=%0d)", req, what, act, exp, nbits);
      end
   endtask

   task automatic want_idle(int at, int req);
      exp_t e;
      e.at = at; e.req = req; e.inf = 1'b0; e.pos = -1; e.fas = 1'b0;
      q.push_back(e);
   endtask

   task automatic want_lock(int at, int req);
      exp_t e;
      e.at = at; e.req = req; e.inf = 1'b1;
      e.pos = (at - 1) % 256;
      e.fas = ((at - 1) % 512) < 256;
      q.push_back(e);
   endtask

   // monitor: pops expected items when the consumed bit count reaches them
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (!rst && q.size() > 0 && q[0].at == nbits) begin
            cur = q.pop_front();
            check(cur.req, in_frame === cur.inf, "in_frame", int'(in_frame), int'(cur.inf));
            if (cur.inf) begin
               check(cur.req, int'(bit_pos) == cur.pos, "bit_pos", int'(bit_pos), cur.pos);
               check(cur.req, fas_frame == cur.fas, "fas_frame", int'(fas_frame), int'(cur.fas));
            end
         end
      end
   end

   task automatic start_case(bit res, bit nfe);
      @(negedge clk);
      rst = 1'b1; bit_en = 1'b0; resync_req = 1'b0;
      resume_en = res; nfas_loss_en = nfe;
      q.delete();
      nbits = 0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      want_idle(0, 1);   // R1: reset leaves the block hunting
   endtask

   task automatic run_bits(int nb);
      for (int k = 0; k < nb; k++) begin
         @(negedge clk);
         bit_en = 1'b1;
         bit_in = bit_of(k);
         resync_req = (k == rs_at);
         nbits = k + 1;
         if (k % 5 == 3) begin
            @(negedge clk);
            bit_en = 1'b0;
            bit_in = ~bit_in;
            resync_req = 1'b0;
         end
      end
      @(negedge clk);
      bit_en = 1'b0;
      resync_req = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      while (q.size() > 0) begin
         cur = q.pop_front();
         check(cur.req, 1'b0, "unreached check at", nbits, cur.at);
      end
      bad_word = '0; bad_b2 = '0; fake_end = -1; rs_at = -1;
   endtask

   initial begin
      // S1 clean acquisition and counting
      start_case(1'b0, 1'b0);
      want_idle(519, 2);   // R2
      want_lock(520, 2);   // R2
      want_lock(1000, 6);  // R6
      want_lock(1024, 6);  // R6
      run_bits(1100);

      // S2a failed bit-2 check, imitation later in the same frame
      bad_b2[1] = 1'b1; fake_end = 300;
      start_case(1'b0, 1'b0);
      want_idle(300, 3);   // R3
      want_idle(1031, 3);  // R3
      want_lock(1032, 3);  // R3
      run_bits(1100);

      // S2b same failure with resume: old position skipped once
      bad_b2[1] = 1'b1;
      start_case(1'b1, 1'b0);
      want_idle(1032, 5);  // R5
      want_idle(1543, 5);  // R5
      want_lock(1544, 5);  // R5
      run_bits(1700);

      // S3 word missing in frame n+2
      bad_word[2] = 1'b1;
      start_case(1'b0, 1'b0);
      want_idle(520, 4);   // R4
      want_idle(1300, 4);  // R4
      want_lock(1544, 4);  // R4
      run_bits(1700);

      // S4 word loss after three bad, survive two bad
      bad_word[4] = 1'b1; bad_word[6] = 1'b1; bad_word[8] = 1'b1;
      bad_word[14] = 1'b1; bad_word[16] = 1'b1;
      start_case(1'b0, 1'b0);
      want_lock(2055, 7);  // R7
      want_idle(2056, 7);  // R7
      want_lock(3080, 7);  // R7
      want_lock(4616, 7);  // R7
      want_lock(4700, 10); // R10
      run_bits(4800);

      // S5a bit-2 loss enabled
      bad_b2[3] = 1'b1; bad_b2[5] = 1'b1; bad_b2[7] = 1'b1;
      start_case(1'b0, 1'b1);
      want_lock(1793, 8);  // R8
      want_idle(1794, 8);  // R8
      want_lock(2568, 8);  // R8
      run_bits(2700);

      // S5b same errors, rule disabled
      bad_b2[3] = 1'b1; bad_b2[5] = 1'b1; bad_b2[7] = 1'b1;
      start_case(1'b0, 1'b0);
      want_lock(1794, 8);  // R8
      want_lock(2600, 8);  // R8
      run_bits(2700);

      // S6a external re-hunt without resume
      rs_at = 600;
      start_case(1'b0, 1'b0);
      want_lock(600, 9);   // R9
      want_idle(601, 9);   // R9
      want_idle(1543, 9);  // R9
      want_lock(1544, 9);  // R9
      run_bits(1700);

      // S6b external re-hunt with resume
      rs_at = 600;
      start_case(1'b1, 1'b0);
      want_idle(601, 9);   // R9
      want_idle(1544, 5);  // R5
      want_idle(2055, 5);  // R5
      want_lock(2056, 5);  // R5
      run_bits(2200);

      // S7 imitation at an unaligned offset is tried and rejected
      bad_word[0] = 1'b1; fake_end = 106;
      start_case(1'b0, 1'b0);
      want_idle(357, 11);  // R11
      want_idle(619, 11);  // R11
      want_lock(1544, 11); // R11
      run_bits(1700);

      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog all requirements actual=%0d expected=%0d", nbits, 0);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule